// File: doc/BRIEF.md
# Reversible-Gate 4x4 Vedic Multiplier

This block multiplies two unsigned 4-bit operands and returns their 8-bit product. It has no clock and no storage. It is written as a structural netlist of reversible gates. Every gate has as many outputs as inputs, and each input vector maps to exactly one output vector. Constant inputs are tied to zero. Gate outputs that the function does not need are left as unused lines.

The operands are split into high and low 2-bit halves. Four 2x2 vertical-crosswise cells each form a 4-bit partial product from one pair of halves. No wire feeds two gate inputs. Each operand bit is duplicated by a copy gate, so that each half reaches its two cells. Two 4-bit ripple adders and one 5-bit ripple adder combine the partial products. The first stage of every adder has no carry in, so it is a three-line AND/XOR gate used as a half adder. The later stages are four-line full-adder gates. The top module exposes the totals for gate count, constant inputs, unused outputs and quantum cost as compile-time localparams.

Top module: `vedic_rev_mul4`

## Requirements
- R1: For every pair of unsigned 4-bit operands, `p_o` equals `a_i * b_i` (an 8-bit result).
- R2: `p_o[1:0]` equals the low two bits of `a_i[1:0] * b_i[1:0]`, and in particular `p_o[0] = a_i[0] & b_i[0]`.
- R3: The copy gate maps (a,b) to (a, a^b), and its four input vectors give four distinct outputs.
- R4: The three-line gate maps (a,b,c) to (a, a^b, (a&b)^c), and its eight input vectors give eight distinct outputs.
- R5: The four-line full-adder gate maps (a,b,c,d) to (a, b, a^b^c, ((a^b)&c)^(a&b)^d), and its sixteen input vectors give sixteen distinct outputs.
- R6: The five-line partial-product gate maps (a,b,c,d,e) to (a, b, c, (a&b)^d, (a&c)^e), and its thirty-two input vectors give thirty-two distinct outputs.
- R7: The 2x2 cell returns the 4-bit product of its two 2-bit operands for all sixteen input pairs.
- R8: A W-bit ripple adder returns the (W+1)-bit sum of its operands, for W of 4 and of 5.
- R9: The reported costs are 42 gates, 49 constant inputs, 49 unused outputs and a quantum cost of 185.
- R10: If either operand is zero, `p_o` is zero.
- R11: With both operands at 15, `p_o` is 225, the largest product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | Unsigned multiplicand |
| b_i | input | 4 | Unsigned multiplier |
| p_o | output | 8 | Unsigned product |

## Verification
The assertions take it that both operands are two-state and held steady while the product settles. They read the outputs only after the combinational network has been evaluated, since the block has no clock to mark when its result is valid. The bench changes the operands on one clock edge and compares the product on the opposite edge, so every value it checks has settled. Each primitive gate, the 2x2 cell and both adder widths are also driven directly with every input vector.

// File: rtl/vedic_rev_mul4.sv
module rev_feynman (
  input  logic a,
  input  logic b,
  output logic p,
  output logic q
);
  assign p = a;
  assign q = a ^ b;
endmodule

module rev_peres (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic p,
  output logic q,
  output logic r
);
  assign p = a;
  assign q = a ^ b;
  assign r = (a & b) ^ c;
endmodule

module rev_hng (
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  output logic p,
  output logic q,
  output logic r,
  output logic s
);
  assign p = a;
  assign q = b;
  assign r = a ^ b ^ c;
  assign s = ((a ^ b) & c) ^ (a & b) ^ d;
endmodule

module rev_ppg5 (
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  input  logic e,
  output logic p,
  output logic q,
  output logic r,
  output logic s,
  output logic t
);
  assign p = a;
  assign q = b;
  assign r = c;
  assign s = (a & b) ^ d;
  assign t = (a & c) ^ e;
endmodule

module rev_ut2 (
  input  logic [1:0] x,
  input  logic [1:0] y,
  output logic [3:0] q
);
  logic [5:0] unused_g;
  logic y0c, y1c, x1c, t_mid, m_cross, hh, cy;

  rev_ppg5  u_pp (.a(x[0]), .b(y[0]), .c(y[1]), .d(1'b0), .e(1'b0),
                  .p(unused_g[0]), .q(y0c), .r(y1c), .s(q[0]), .t(t_mid));
  rev_peres u_p1 (.a(x[1]), .b(y0c), .c(1'b0), .p(x1c), .q(unused_g[1]), .r(m_cross));
  rev_peres u_p2 (.a(x1c), .b(y1c), .c(1'b0), .p(unused_g[2]), .q(unused_g[3]), .r(hh));
  rev_peres u_p3 (.a(t_mid), .b(m_cross), .c(1'b0), .p(unused_g[4]), .q(q[1]), .r(cy));
  rev_peres u_p4 (.a(cy), .b(hh), .c(1'b0), .p(unused_g[5]), .q(q[2]), .r(q[3]));
endmodule

module rev_rca #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W:0]   s
);
  logic [W:0]   c;
  logic [2*W-2:0] unused_g;

  assign c[0] = 1'b0;
  rev_peres u_half (.a(x[0]), .b(y[0]), .c(1'b0), .p(unused_g[0]), .q(s[0]), .r(c[1]));

  for (genvar i = 1; i < W; i++) begin : g_full
    rev_hng u_fa (.a(x[i]), .b(y[i]), .c(c[i]), .d(1'b0),
                  .p(unused_g[2*i-1]), .q(unused_g[2*i]), .r(s[i]), .s(c[i+1]));
  end

  assign s[W] = c[W];
endmodule

module vedic_rev_mul4 (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  output logic [7:0] p_o
);
  localparam int UT_GATES = 5;
  localparam int UT_CONST = 6;
  localparam int UT_GARB  = 6;
  localparam int UT_QC    = 26;
  localparam int COPIES   = 8;
  localparam int ZERO_EXT = 4;

  function automatic int rca_gates(int w); return w; endfunction
  function automatic int rca_garb(int w);  return 1 + 2 * (w - 1); endfunction
  function automatic int rca_qc(int w);    return 4 + 6 * (w - 1); endfunction

  localparam int COST_GATES   = 4 * UT_GATES + COPIES + 2 * rca_gates(4) + rca_gates(5) + 1;
  localparam int COST_CONST   = 4 * UT_CONST + COPIES + 2 * rca_gates(4) + rca_gates(5) + ZERO_EXT;
  localparam int COST_GARBAGE = 4 * UT_GARB + 2 * rca_garb(4) + rca_garb(5) + 2;
  localparam int COST_QC      = 4 * UT_QC + COPIES + 2 * rca_qc(4) + rca_qc(5) + 1;

  logic [3:0] a_x, a_y, b_x, b_y;
  logic [3:0] q0, q1, q2, q3;
  logic [4:0] s1, s2;
  logic [5:0] v, s3;
  logic       top_bit;
  logic [1:0] unused_top;

  for (genvar k = 0; k < 4; k++) begin : g_copy
    rev_feynman u_ca (.a(a_i[k]), .b(1'b0), .p(a_x[k]), .q(a_y[k]));
    rev_feynman u_cb (.a(b_i[k]), .b(1'b0), .p(b_x[k]), .q(b_y[k]));
  end

  rev_ut2 u_q0 (.x(a_x[1:0]), .y(b_x[1:0]), .q(q0));
  rev_ut2 u_q1 (.x(a_x[3:2]), .y(b_y[1:0]), .q(q1));
  rev_ut2 u_q2 (.x(a_y[1:0]), .y(b_x[3:2]), .q(q2));
  rev_ut2 u_q3 (.x(a_y[3:2]), .y(b_y[3:2]), .q(q3));

  rev_rca #(.W(4)) u_add1 (.x({2'b00, q0[3:2]}), .y(q1), .s(s1));
  rev_rca #(.W(4)) u_add2 (.x({2'b00, q2[3:2]}), .y(q3), .s(s2));

  assign v = {s2[3:0], q2[1:0]};
  assign unused_top[1] = s2[4];

  rev_rca #(.W(5)) u_add3 (.x(s1), .y(v[4:0]), .s(s3));
  rev_feynman u_msb (.a(s3[5]), .b(v[5]), .p(unused_top[0]), .q(top_bit));

  assign p_o = {top_bit, s3[4:0], q0[1:0]};
endmodule

// File: rtl/vedic_rev_mul4_chk.sv
module vedic_rev_mul4_chk (
  input logic [3:0] a_i,
  input logic [3:0] b_i,
  input logic [7:0] p_o
);
  always_comb begin
    p_exact_product_r1: assert (p_o == 8'(a_i) * 8'(b_i));
    p_low_pair_r2: assert (p_o[1:0] == 2'(a_i[1:0] * b_i[1:0]));
    p_lsb_r2: assert (p_o[0] == (a_i[0] & b_i[0]));
    if (a_i == 4'd0 || b_i == 4'd0)
      p_zero_operand_r10: assert (p_o == 8'd0);
    if (a_i == 4'd15 && b_i == 4'd15)
      p_full_scale_r11: assert (p_o == 8'd225);
  end
endmodule

bind vedic_rev_mul4 vedic_rev_mul4_chk u_chk (.a_i(a_i), .b_i(b_i), .p_o(p_o));

// File: tb/vedic_rev_mul4_bench.sv
module vedic_rev_mul4_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [3:0] a_i = 4'd0, b_i = 4'd0;
  logic [7:0] p_o;
  vedic_rev_mul4 u_vedic_rev_mul4 (.a_i(a_i), .b_i(b_i), .p_o(p_o));

  logic f_a, f_b, f_p, f_q;
  rev_feynman u_f (.a(f_a), .b(f_b), .p(f_p), .q(f_q));
  logic e_a, e_b, e_c, e_p, e_q, e_r;
  rev_peres u_pe (.a(e_a), .b(e_b), .c(e_c), .p(e_p), .q(e_q), .r(e_r));
  logic h_a, h_b, h_c, h_d, h_p, h_q, h_r, h_s;
  rev_hng u_h (.a(h_a), .b(h_b), .c(h_c), .d(h_d), .p(h_p), .q(h_q), .r(h_r), .s(h_s));
  logic g_a, g_b, g_c, g_d, g_e, g_p, g_q, g_r, g_s, g_t;
  rev_ppg5 u_g (.a(g_a), .b(g_b), .c(g_c), .d(g_d), .e(g_e),
                .p(g_p), .q(g_q), .r(g_r), .s(g_s), .t(g_t));
  logic [1:0] c_x, c_y;
  logic [3:0] c_q;
  rev_ut2 u_cell (.x(c_x), .y(c_y), .q(c_q));
  logic [3:0] r4_x, r4_y;
  logic [4:0] r4_s;
  rev_rca #(.W(4)) u_r4 (.x(r4_x), .y(r4_y), .s(r4_s));
  logic [4:0] r5_x, r5_y;
  logic [5:0] r5_s;
  rev_rca #(.W(5)) u_r5 (.x(r5_x), .y(r5_y), .s(r5_s));

  typedef struct {
    logic [3:0] a;
    logic [3:0] b;
    logic [7:0] p;
    string      req;
  } sb_item_t;
  sb_item_t sb_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] x, input logic [3:0] y, input string req);
    @(posedge clk);
    a_i = x;
    b_i = y;
    sb_q.push_back('{x, y, 8'(x) * 8'(y), req});
  endtask

  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      check(p_o == it.p, it.req, int'(p_o), int'(it.p));
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bit [31:0] seen;
    repeat (2) @(negedge clk);
    check(p_o == 8'd0, "R10 reset-state zero operands", int'(p_o), 0);

    seen = '0;
    for (int v = 0; v < 4; v++) begin
      {f_a, f_b} = 2'(v);
      #1;
      check({f_p, f_q} == {f_a, f_a ^ f_b}, "R3 copy gate map", int'({f_p, f_q}), int'({f_a, f_a ^ f_b}));
      check(!seen[{f_p, f_q}], "R3 copy gate distinct", 1, 0);
      seen[{f_p, f_q}] = 1'b1;
    end

    seen = '0;
    for (int v = 0; v < 8; v++) begin
      {e_a, e_b, e_c} = 3'(v);
      #1;
      check({e_p, e_q, e_r} == {e_a, e_a ^ e_b, (e_a & e_b) ^ e_c}, "R4 three-line map",
            int'({e_p, e_q, e_r}), int'({e_a, e_a ^ e_b, (e_a & e_b) ^ e_c}));
      check(!seen[{e_p, e_q, e_r}], "R4 three-line distinct", 1, 0);
      seen[{e_p, e_q, e_r}] = 1'b1;
    end

    seen = '0;
    for (int v = 0; v < 16; v++) begin
      logic [3:0] ex;
      {h_a, h_b, h_c, h_d} = 4'(v);
      ex = {h_a, h_b, h_a ^ h_b ^ h_c, ((h_a ^ h_b) & h_c) ^ (h_a & h_b) ^ h_d};
      #1;
      check({h_p, h_q, h_r, h_s} == ex, "R5 full-adder gate map", int'({h_p, h_q, h_r, h_s}), int'(ex));
      check(!seen[{h_p, h_q, h_r, h_s}], "R5 full-adder gate distinct", 1, 0);
      seen[{h_p, h_q, h_r, h_s}] = 1'b1;
    end

    seen = '0;
    for (int v = 0; v < 32; v++) begin
      logic [4:0] ex;
      {g_a, g_b, g_c, g_d, g_e} = 5'(v);
      ex = {g_a, g_b, g_c, (g_a & g_b) ^ g_d, (g_a & g_c) ^ g_e};
      #1;
      check({g_p, g_q, g_r, g_s, g_t} == ex, "R6 partial-product gate map",
            int'({g_p, g_q, g_r, g_s, g_t}), int'(ex));
      check(!seen[{g_p, g_q, g_r, g_s, g_t}], "R6 partial-product gate distinct", 1, 0);
      seen[{g_p, g_q, g_r, g_s, g_t}] = 1'b1;
    end

    for (int v = 0; v < 16; v++) begin
      {c_x, c_y} = 4'(v);
      #1;
      check(c_q == 4'(c_x) * 4'(c_y), "R7 2x2 cell product", int'(c_q), int'(4'(c_x) * 4'(c_y)));
    end

    for (int v = 0; v < 256; v++) begin
      {r4_x, r4_y} = 8'(v);
      #1;
      check(r4_s == 5'(r4_x) + 5'(r4_y), "R8 4-bit adder", int'(r4_s), int'(5'(r4_x) + 5'(r4_y)));
    end
    for (int v = 0; v < 1024; v++) begin
      {r5_x, r5_y} = 10'(v);
      #1;
      check(r5_s == 6'(r5_x) + 6'(r5_y), "R8 5-bit adder", int'(r5_s), int'(6'(r5_x) + 6'(r5_y)));
    end

    check(u_vedic_rev_mul4.COST_GATES == 42, "R9 gate count", u_vedic_rev_mul4.COST_GATES, 42);
    check(u_vedic_rev_mul4.COST_CONST == 49, "R9 constant inputs", u_vedic_rev_mul4.COST_CONST, 49);
    check(u_vedic_rev_mul4.COST_GARBAGE == 49, "R9 unused outputs", u_vedic_rev_mul4.COST_GARBAGE, 49);
    check(u_vedic_rev_mul4.COST_QC == 185, "R9 quantum cost", u_vedic_rev_mul4.COST_QC, 185);

    rst_n = 1'b1;
    drive(4'd0, 4'd9, "R10 zero multiplicand");
    drive(4'd11, 4'd0, "R10 zero multiplier");
    drive(4'd15, 4'd15, "R11 full scale");
    drive(4'd3, 4'd3, "R2 low halves only");
    for (int k = 0; k < 4; k++) drive(4'(1 << k), 4'(8 >> k), "R1 walking ones");
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        drive(4'(x), 4'(y), "R1 exhaustive product");
    drive(4'd15, 4'd15, "R11 full scale repeat");
    repeat (3) @(posedge clk);

    check(sb_q.size() == 0, "R1 scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule